// File: doc/BRIEF.md
# Tagged Receive Interrupt Coalescer

This block decides when one CAN channel's receive side should interrupt the host. It counts incoming messages in a pending batch. It raises an interrupt when the batch reaches a count limit, or when a time limit measured in timebase ticks has passed since the batch started. Whichever comes first wins. A release of a transmit page also forces an interrupt, even when no messages are pending.

Each interrupt produces a one-cycle status word. The word carries a rolling 4-bit tag, the batch size and a page-release flag. The block then stays quiet until the host writes an acknowledge. The value written is the next tag to use, which the host computes as the tag it read plus one, modulo 16. A status word whose tag the host does not expect is treated as not belonging to this channel.

Control bits are changed only through separate set and clear addresses. The control register has three bits: uncached mode, path hold and interrupt enable. Two limits share one threshold register.

Top module: `rx_irq_coalescer`

## Requirements
- R1: After reset, `irq` and `status_valid` are low and the control register reads 0x0003_0000 (path hold and uncached set, interrupt enable clear). The threshold register reads 0x0000_0A10 (time limit 10 in bits [15:8], count limit 16 in bits [7:0]). The tag register reads 0.
- R2: Register addresses: 0 = control set, 1 = control clear, 2 = thresholds, 3 = acknowledge. Reads return the control register at addresses 0 and 1, the thresholds at 2 and the expected tag at 3, one cycle after the address is presented. A write to address 0 sets exactly the control bits written as 1, and a write to address 1 clears exactly those bits; 0 bits leave a bit unchanged. Control bit 16 is uncached, bit 17 is path hold and bit 18 is interrupt enable.
- R3: The status word holds the tag in bits [3:0], the message count in bits [10:4] and the page-release flag in bit 16; all other bits are zero.
- R4: With no timeout, a status word is issued once the pending count reaches the count limit, and not before.
- R5: With fewer messages pending than the count limit, a status word is issued after the time-limit-th tick that occurs while messages are pending, and not before.
- R6: After a status word, `irq` stays high and no further status word is issued until an acknowledge is written. Messages arriving meanwhile accumulate and are reported in the next word.
- R7: The value written to the acknowledge register (bits [3:0]) becomes the tag of the next status word and reads back at address 3.
- R8: A page-release pulse with no messages pending yields a status word with count 0 and bit 16 set.
- R9: While path hold is set, no status word is issued, `irq` is low, and pending messages and page releases are discarded. The expected tag keeps its value.
- R10: No status word is issued unless interrupt enable is set and an acknowledge has been written since path hold was last cleared.
- R11: A message arriving in the cycle a status word is decided is not counted in that word; it starts the next batch.
- R12: The pending count saturates at 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| msg_rx | input | 1 | One pulse per received message |
| link_rel | input | 1 | Transmit page released pulse |
| tick | input | 1 | Prescaled timebase enable |
| irq | output | 1 | Interrupt, high from status word to acknowledge |
| status_valid | output | 1 | One-cycle strobe for `status_word` |
| status_word | output | 32 | Tag, count and release flag |

## Verification
A message can arrive in the same cycle that a batch is closed. The count limit is set to 4 and five messages are driven back to back, so the fifth lands exactly on the deciding edge. The scoreboard expects the first status word to report 4. After the acknowledge, only three more messages must complete the next batch of 4, which shows that the fifth message was carried into that batch.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int TAG_W    = 4;
  localparam int CNT_W    = 7;
  localparam int CNT_LSB  = 4;
  localparam int LINK_BIT = 16;
  localparam int LIM_W    = 8;
  localparam int WORD_W   = 32;

  localparam int CTL_LSB  = 16;
  localparam int CTL_W    = 3;
  localparam int CTL_UNC  = 0;
  localparam int CTL_HOLD = 1;
  localparam int CTL_IEN  = 2;

  typedef enum logic [1:0] {
    ADDR_SET = 2'd0,
    ADDR_CLR = 2'd1,
    ADDR_THR = 2'd2,
    ADDR_ACK = 2'd3
  } reg_addr_e;

  localparam logic [CTL_W-1:0] CTL_INIT = 3'b011;
  localparam logic [LIM_W-1:0] DEF_CNT_LIM  = 8'd16;
  localparam logic [LIM_W-1:0] DEF_TIME_LIM = 8'd10;
endpackage

// File: rtl/coal_regs.sv
module coal_regs
  import coal_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             path_hold,
  output logic             irq_en,
  output logic [LIM_W-1:0] cnt_lim,
  output logic [LIM_W-1:0] time_lim,
  output logic [TAG_W-1:0] tag,
  output logic             armed,
  output logic             ack
);
  logic [CTL_W-1:0] ctl_q;
  logic [CTL_W-1:0] wr_bits;
  logic [DW-1:0]    rd_mux;
  logic             unused_wbits;

  assign wr_bits   = wdata[CTL_LSB +: CTL_W];
  assign ack       = we && (addr == ADDR_ACK);
  assign path_hold = ctl_q[CTL_HOLD];
  assign irq_en    = ctl_q[CTL_IEN];
  assign unused_wbits = ^{wdata[DW-1:CTL_LSB+CTL_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= CTL_INIT;
      cnt_lim  <= DEF_CNT_LIM;
      time_lim <= DEF_TIME_LIM;
      tag      <= '0;
    end else if (we) begin
      case (addr)
        ADDR_SET: ctl_q <= ctl_q | wr_bits;
        ADDR_CLR: ctl_q <= ctl_q & ~wr_bits;
        ADDR_THR: begin
          cnt_lim  <= wdata[LIM_W-1:0];
          time_lim <= wdata[2*LIM_W-1:LIM_W];
        end
        default:  tag <= wdata[TAG_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl_q[CTL_HOLD]) armed <= 1'b0;
    else if (ack)               armed <= 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_SET, ADDR_CLR: rd_mux[CTL_LSB +: CTL_W] = ctl_q;
      ADDR_THR: begin
        rd_mux[LIM_W-1:0]       = cnt_lim;
        rd_mux[2*LIM_W-1:LIM_W] = time_lim;
      end
      default:            rd_mux[TAG_W-1:0] = tag;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/coal_batch.sv
module coal_batch
  import coal_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int LW = LIM_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          path_hold,
  input  logic          waiting,
  input  logic          fire,
  input  logic          msg_rx,
  input  logic          link_rel,
  input  logic          tick,
  output logic [CW-1:0] pend_cnt,
  output logic          link_pend,
  output logic [LW-1:0] tmr
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [LW-1:0] TMR_MAX = {LW{1'b1}};

  logic clear;
  assign clear = rst || path_hold;

  always_ff @(posedge clk) begin
    if (clear)                              pend_cnt <= '0;
    else if (fire)                          pend_cnt <= msg_rx ? CW'(1) : '0;
    else if (msg_rx && pend_cnt != CNT_MAX) pend_cnt <= pend_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clear)     link_pend <= 1'b0;
    else if (fire) link_pend <= link_rel;
    else           link_pend <= link_pend | link_rel;
  end

  always_ff @(posedge clk) begin
    if (clear || fire || waiting)                        tmr <= '0;
    else if (tick && pend_cnt != '0 && tmr != TMR_MAX) tmr <= tmr + 1'b1;
  end
endmodule

// File: rtl/coal_fire.sv
module coal_fire
  import coal_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int LW = LIM_W,
  parameter int TW = TAG_W,
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          path_hold,
  input  logic          irq_en,
  input  logic          armed,
  input  logic          ack,
  input  logic [CW-1:0] pend_cnt,
  input  logic          link_pend,
  input  logic [LW-1:0] tmr,
  input  logic [LW-1:0] cnt_lim,
  input  logic [LW-1:0] time_lim,
  input  logic [TW-1:0] tag,
  output logic          fire,
  output logic          waiting,
  output logic          status_valid,
  output logic [DW-1:0] status_word
);
  logic          have_msgs;
  logic          trig;
  logic [DW-1:0] word_c;

  assign have_msgs = (pend_cnt != '0);
  assign trig = link_pend ||
                (have_msgs && ((LW'(pend_cnt) >= cnt_lim) || (tmr >= time_lim)));
  assign fire = !waiting && armed && irq_en && !path_hold && trig;

  always_comb begin
    word_c = '0;
    word_c[TW-1:0]          = tag;
    word_c[CNT_LSB +: CW]   = pend_cnt;
    word_c[LINK_BIT]        = link_pend;
  end

  always_ff @(posedge clk) begin
    if (rst || path_hold) waiting <= 1'b0;
    else if (fire)        waiting <= 1'b1;
    else if (ack)         waiting <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_valid <= 1'b0;
      status_word  <= '0;
    end else begin
      status_valid <= fire;
      if (fire) status_word <= word_c;
    end
  end
endmodule

// File: rtl/rx_irq_coalescer.sv
module rx_irq_coalescer
  import coal_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int CW = CNT_W,
  parameter int LW = LIM_W,
  parameter int TW = TAG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          msg_rx,
  input  logic          link_rel,
  input  logic          tick,
  output logic          irq,
  output logic          status_valid,
  output logic [DW-1:0] status_word
);
  logic          path_hold, irq_en, armed, ack, fire, waiting, link_pend;
  logic [LW-1:0] cnt_lim, time_lim, tmr;
  logic [TW-1:0] tag;
  logic [CW-1:0] pend_cnt;

  coal_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .path_hold(path_hold), .irq_en(irq_en),
    .cnt_lim(cnt_lim), .time_lim(time_lim), .tag(tag), .armed(armed), .ack(ack)
  );

  coal_batch #(.CW(CW), .LW(LW)) u_batch (
    .clk(clk), .rst(rst), .path_hold(path_hold), .waiting(waiting), .fire(fire),
    .msg_rx(msg_rx), .link_rel(link_rel), .tick(tick),
    .pend_cnt(pend_cnt), .link_pend(link_pend), .tmr(tmr)
  );

  coal_fire #(.CW(CW), .LW(LW), .TW(TW), .DW(DW)) u_fire (
    .clk(clk), .rst(rst), .path_hold(path_hold), .irq_en(irq_en), .armed(armed),
    .ack(ack), .pend_cnt(pend_cnt), .link_pend(link_pend), .tmr(tmr),
    .cnt_lim(cnt_lim), .time_lim(time_lim), .tag(tag), .fire(fire),
    .waiting(waiting), .status_valid(status_valid), .status_word(status_word)
  );

  assign irq = waiting;
endmodule

// File: rtl/coal_chk.sv
module coal_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic        path_hold,
  input logic        irq,
  input logic        status_valid,
  input logic [31:0] status_word
);
  logic ack_wr;
  assign ack_wr = reg_we && (reg_addr == 2'd3);

  // R9: hold forces the interrupt low on the next cycle
  assert_irq_low_in_hold_R9: assert property (@(posedge clk) disable iff (rst)
    path_hold |=> !irq);

  // R6: a status strobe is never two cycles long
  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    status_valid |=> !status_valid);

  // R6: no new word while an interrupt is outstanding and unacknowledged
  assert_quiet_until_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack_wr && !path_hold) |=> !status_valid);

  // R6: the interrupt rises together with a status strobe
  assert_irq_with_word_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> status_valid);

  // R3: reserved bits of the status word are zero
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
    status_valid |-> (status_word[31:17] == 15'd0 && status_word[15:11] == 5'd0));

  // R8: every word reports messages or a page release
  assert_word_not_empty_R8: assert property (@(posedge clk) disable iff (rst)
    status_valid |-> (status_word[10:4] != 7'd0 || status_word[16]));
endmodule

bind rx_irq_coalescer coal_chk u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .path_hold(path_hold), .irq(irq), .status_valid(status_valid),
  .status_word(status_word)
);

// File: tb/sim_rx_irq_coalescer.sv
module sim_rx_irq_coalescer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msg_rx = 1'b0, link_rel = 1'b0, tick = 1'b0;
  logic        irq, status_valid;
  logic [31:0] status_word;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] expq[$];

  always #2 clk = ~clk;

  rx_irq_coalescer u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_rx(msg_rx),
    .link_rel(link_rel), .tick(tick), .irq(irq), .status_valid(status_valid),
    .status_word(status_word)
  );

  function automatic logic [31:0] mk(input int tg, input int cnt, input bit lnk);
    logic [31:0] w = '0;
    w[3:0]  = tg[3:0];
    w[10:4] = cnt[6:0];
    w[16]   = lnk;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pop expected words as the design produces them
  always @(negedge clk) begin
    if (!rst && status_valid) begin
      if (expq.size() == 0) chk("R4/R6 unexpected status word", status_word, 32'hxxxx_xxxx);
      else chk("R3 status word", status_word, expq.pop_front());
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); reg_addr = a;
    @(negedge clk); chk(req, reg_rdata, exp);
  endtask

  task automatic msgs(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); msg_rx = 1'b1; end
    @(negedge clk); msg_rx = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 status_valid", {31'd0, status_valid}, 32'd0);
    rd(2'd0, 32'h0003_0000, "R1 control");
    rd(2'd2, 32'h0000_0A10, "R1 thresholds");
    rd(2'd3, 32'h0, "R1 tag");

    // R2 set/clear semantics
    wr(2'd0, 32'h0004_0000);
    rd(2'd0, 32'h0007_0000, "R2 set enable");
    wr(2'd1, 32'h0001_0000);
    rd(2'd1, 32'h0006_0000, "R2 clear uncached");
    wr(2'd0, 32'h0);
    rd(2'd0, 32'h0006_0000, "R2 zero write no effect");
    wr(2'd1, 32'h0002_0000);
    rd(2'd0, 32'h0004_0000, "R2 release hold");

    // R10: enabled but not yet acknowledged -> silent
    msgs(20);
    idle(5);
    chk("R10 irq before first ack", {31'd0, irq}, 32'd0);
    expq.push_back(mk(1, 20, 0));
    wr(2'd3, 32'd1);
    idle(3);
    rd(2'd3, 32'd1, "R7 tag readback");
    chk("R6 irq held", {31'd0, irq}, 32'd1);

    // R6: messages while waiting accumulate
    msgs(5);
    idle(5);
    chk("R6 irq still high", {31'd0, irq}, 32'd1);
    wr(2'd3, 32'd2);
    chk("R6 irq low after ack", {31'd0, irq}, 32'd0);
    msgs(10);
    idle(5);
    // R4: 16th pending message reaches the limit
    expq.push_back(mk(2, 16, 0));
    msgs(1);
    idle(4);

    // R5: timeout with 2 pending
    wr(2'd3, 32'd3);
    msgs(2);
    ticks(9);
    idle(4);
    expq.push_back(mk(3, 2, 0));
    ticks(1);
    idle(4);

    // R8: page release alone
    wr(2'd3, 32'd4);
    expq.push_back(mk(4, 0, 1));
    @(negedge clk); link_rel = 1'b1;
    @(negedge clk); link_rel = 1'b0;
    idle(4);

    // R11: message landing on the deciding edge joins the next batch
    wr(2'd3, 32'd5);
    wr(2'd2, 32'h0000_0A04);
    expq.push_back(mk(5, 4, 0));
    msgs(5);
    idle(4);
    wr(2'd3, 32'd6);
    idle(3);
    expq.push_back(mk(6, 4, 0));
    msgs(3);
    idle(4);

    // R12: saturation of the pending count
    wr(2'd3, 32'd7);
    wr(2'd2, 32'h0000_FFC8);
    msgs(130);
    idle(3);
    expq.push_back(mk(7, 127, 0));
    wr(2'd2, 32'h0000_0A64);
    idle(4);

    // R9: hold discards and silences, tag kept
    wr(2'd3, 32'd8);
    msgs(2);
    wr(2'd0, 32'h0002_0000);
    wr(2'd2, 32'h0000_0A01);
    msgs(3);
    idle(3);
    chk("R9 irq low in hold", {31'd0, irq}, 32'd0);
    rd(2'd3, 32'd8, "R9 tag kept");
    wr(2'd1, 32'h0002_0000);
    idle(5);
    wr(2'd3, 32'd9);
    idle(5);
    expq.push_back(mk(9, 1, 0));
    msgs(1);
    idle(5);

    chk("R6 all expected words seen", expq.size(), 32'd0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule